// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers 32 level-sensitive interrupt request lines and steers each into one of three classes: a fast class, a vectored IRQ class and a plain IRQ class. Fast-class requests are ORed onto a single fast-interrupt output. All other enabled requests drive the IRQ output. The fast class has the highest priority, the vectored class is in the middle, and the plain class is lowest.

Sixteen vector slots each pair a source number with a handler address. When the core takes an IRQ, it reads the vector register. The read returns the handler address of the best pending vectored request, or a programmable default address when only plain requests are waiting.

A vector read that returns a slot latches that slot as the active level. Equal and lower slots are held off until the core writes the vector register to signal end of interrupt. Only one active level is tracked. Nesting further than that belongs to the core.

Top module: `irqv_ctrl`

## Requirements
- R1: A read of word 0x00 returns the raw request lines, one bit per source, whatever the enable and class settings are.
- R2: Word 0x03 holds one enable bit per source. fiq_o and irq_o are registered. Each asserts one clock after an enabled request of its class appears. Clearing the enable bit drops the source from both outputs within one clock after the write.
- R3: Word 0x04 holds one class bit per source, where 1 selects the fast class. Any enabled fast-class request raises fiq_o. It never shows in the IRQ status and never yields a slot handler address. Word 0x02 returns the fast-class status: request AND enable AND class bit.
- R4: A read of word 0x01 returns the IRQ status: request AND enable AND NOT class bit.
- R5: Word 0x10+n is the control word of slot n, with bits 4:0 holding the source number and bit 5 the slot enable. Word 0x20+n holds the handler address of slot n. A read of word 0x05 returns the handler address of the lowest-numbered enabled slot whose source is in the IRQ status.
- R6: Word 0x06 holds the default handler address. A vector read with no eligible slot returns it and latches no level. This covers both cases: only plain requests pending, or nothing pending.
- R7: A vector read that returns slot k makes slot k active. Until the next write to word 0x05, later vector reads consider only slots below k. If none of those is pending, the read returns the default address.
- R8: Read data appears on bus_rdata_o one clock after the read access. Writable words read back their stored value.
- R9: After reset, every register is zero, no level is active, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 32 | Level-sensitive request lines |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the clock after a read |
| fiq_o | output | 1 | Fast-interrupt request to the core |
| irq_o | output | 1 | IRQ request to the core |

## Verification
Two things can land on the same clock edge: a change on the request lines and the vector read that resolves priority. The bench drives both in the same cycle. In one case a higher-priority source drops exactly as the read is issued. In another, requests are raised while a level is held active. The expected handler address follows from the request pattern in force at that edge together with the active-level rule.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_RAW   = 6'h00;
  localparam logic [ADDR_W-1:0] A_IRQST = 6'h01;
  localparam logic [ADDR_W-1:0] A_FIQST = 6'h02;
  localparam logic [ADDR_W-1:0] A_EN    = 6'h03;
  localparam logic [ADDR_W-1:0] A_CLASS = 6'h04;
  localparam logic [ADDR_W-1:0] A_VEC   = 6'h05;
  localparam logic [ADDR_W-1:0] A_DFLT  = 6'h06;
  localparam logic [1:0] RGN_CTRL = 2'b01;
  localparam logic [1:0] RGN_ADDR = 2'b10;
endpackage

// File: rtl/irqv_first_set.sv
module irqv_first_set #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_slots.sv
module irqv_slots #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32,
  localparam int unsigned SRC_W = $clog2(N_SRC),
  localparam int unsigned IDX_W = $clog2(N_SLOT)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ctrl_we_i,
  input  logic                           addr_we_i,
  input  logic [IDX_W-1:0]               idx_i,
  input  logic [DW-1:0]                  wdata_i,
  input  logic [N_SRC-1:0]               pend_i,
  output logic [N_SLOT-1:0][SRC_W-1:0]   slot_src_o,
  output logic [N_SLOT-1:0]              slot_en_o,
  output logic [N_SLOT-1:0][DW-1:0]      slot_addr_o,
  output logic [N_SLOT-1:0]              hit_o
);
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic sel;
    assign sel = (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_src_o[g]  <= '0;
        slot_en_o[g]   <= 1'b0;
        slot_addr_o[g] <= '0;
      end else begin
        if (ctrl_we_i && sel) begin
          slot_src_o[g] <= wdata_i[SRC_W-1:0];
          slot_en_o[g]  <= wdata_i[SRC_W];
        end
        if (addr_we_i && sel) slot_addr_o[g] <= wdata_i;
      end
    end

    assign hit_o[g] = slot_en_o[g] & pend_i[slot_src_o[g]];
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  localparam int unsigned SRC_W = $clog2(N_SRC);
  localparam int unsigned IDX_W = $clog2(N_SLOT);

  logic [N_SRC-1:0] en_q, fast_q, irq_pend, fiq_pend;
  logic [DW-1:0]    dflt_q, rd_val, vec_now;
  logic             active_q;
  logic [IDX_W-1:0] active_idx_q;

  logic [N_SLOT-1:0][SRC_W-1:0] slot_src;
  logic [N_SLOT-1:0]            slot_en, hit, allow, elig;
  logic [N_SLOT-1:0][DW-1:0]    slot_addr;
  logic                         found;
  logic [IDX_W-1:0]             win_idx;

  logic wr, rd, rgn_ctrl_we, rgn_addr_we, vec_rd, vec_wr;
  assign wr          = bus_sel_i & bus_we_i;
  assign rd          = bus_sel_i & ~bus_we_i;
  assign rgn_ctrl_we = wr && (bus_addr_i[5:4] == RGN_CTRL);
  assign rgn_addr_we = wr && (bus_addr_i[5:4] == RGN_ADDR);
  assign vec_rd      = rd && (bus_addr_i == A_VEC);
  assign vec_wr      = wr && (bus_addr_i == A_VEC);

  assign irq_pend = irq_req_i & en_q & ~fast_q;
  assign fiq_pend = irq_req_i & en_q & fast_q;

  irqv_slots #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .DW(DW)) u_slots (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (rgn_ctrl_we),
    .addr_we_i   (rgn_addr_we),
    .idx_i       (bus_addr_i[IDX_W-1:0]),
    .wdata_i     (bus_wdata_i),
    .pend_i      (irq_pend),
    .slot_src_o  (slot_src),
    .slot_en_o   (slot_en),
    .slot_addr_o (slot_addr),
    .hit_o       (hit)
  );

  // active level holds off itself and every slot below it in priority
  for (genvar g = 0; g < N_SLOT; g++) begin : g_allow
    assign allow[g] = !active_q || (IDX_W'(g) < active_idx_q);
  end
  assign elig = hit & allow;

  irqv_first_set #(.N(N_SLOT)) u_pick (
    .vec_i   (elig),
    .found_o (found),
    .idx_o   (win_idx)
  );

  assign vec_now = found ? slot_addr[win_idx] : dflt_q;

  always_comb begin
    rd_val = '0;
    unique case (bus_addr_i[5:4])
      RGN_CTRL: rd_val = DW'({slot_en[bus_addr_i[IDX_W-1:0]],
                              slot_src[bus_addr_i[IDX_W-1:0]]});
      RGN_ADDR: rd_val = slot_addr[bus_addr_i[IDX_W-1:0]];
      default: begin
        case (bus_addr_i)
          A_RAW:   rd_val = DW'(irq_req_i);
          A_IRQST: rd_val = DW'(irq_pend);
          A_FIQST: rd_val = DW'(fiq_pend);
          A_EN:    rd_val = DW'(en_q);
          A_CLASS: rd_val = DW'(fast_q);
          A_VEC:   rd_val = vec_now;
          A_DFLT:  rd_val = dflt_q;
          default: rd_val = '0;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q         <= '0;
      fast_q       <= '0;
      dflt_q       <= '0;
      active_q     <= 1'b0;
      active_idx_q <= '0;
      bus_rdata_o  <= '0;
      fiq_o        <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      fiq_o <= |fiq_pend;
      irq_o <= |irq_pend;
      if (rd) bus_rdata_o <= rd_val;
      if (wr && bus_addr_i == A_EN)    en_q   <= bus_wdata_i[N_SRC-1:0];
      if (wr && bus_addr_i == A_CLASS) fast_q <= bus_wdata_i[N_SRC-1:0];
      if (wr && bus_addr_i == A_DFLT)  dflt_q <= bus_wdata_i;
      if (vec_wr) begin
        active_q <= 1'b0;
      end else if (vec_rd && found) begin
        active_q     <= 1'b1;
        active_idx_q <= win_idx;
      end
    end
  end

  a_r2_irq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_req_i & en_q & ~fast_q)) |=> irq_o);
  a_r3_fiq_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(irq_req_i & en_q & fast_q)) |=> !fiq_o);
  a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (elig[win_idx] &&
               ((elig & ((N_SLOT'(1) << win_idx) - N_SLOT'(1))) == '0)));
  a_r5_latch_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && found) |=> (active_q && active_idx_q == $past(win_idx)));
  a_r6_no_latch_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd && !found && !active_q) |=> !active_q);
  a_r7_eoi_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_wr |=> !active_q);
  a_r7_held_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && found) |-> (win_idx < active_idx_q));
endmodule

// File: tb/test_irqv_ctrl.sv
`timescale 1ns/1ps
module test_irqv_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  irqv_ctrl i_irqv_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= sel && !we;

  // monitor: compare each completed read against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick();
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_req(input logic [5:0] a, input logic [31:0] new_req,
                        input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = new_req;
    sel = 1'b1; we = 1'b0; addr = a;
    tick();
    sel = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, input logic [31:0] e, input string t);
    rd_req(a, req, e, t);
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  localparam logic [31:0] DFLT = 32'hDEF0_0000;
  localparam logic [31:0] H4   = 32'hA000_0004;
  localparam logic [31:0] H31  = 32'hA000_001F;
  localparam logic [31:0] H8   = 32'hA000_0008;

  initial begin
    #(8ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk(fiq, 1'b0, "R9 fiq after reset");
    chk(irq, 1'b0, "R9 irq after reset");
    rd_reg(6'h03, 32'h0, "R9 enable reset");
    rd_reg(6'h05, 32'h0, "R9 default reset");

    req = 32'h8000_0011;
    rd_reg(6'h00, 32'h8000_0011, "R1 raw while disabled");
    rd_reg(6'h01, 32'h0, "R4 status while disabled");
    tick();
    chk(irq, 1'b0, "R2 irq disabled");

    wr_reg(6'h04, 32'h0000_0001);
    wr_reg(6'h03, 32'hFFFF_FFFF);
    tick();
    chk(fiq, 1'b1, "R3 fiq from fast source");
    chk(irq, 1'b1, "R2 irq from irq source");
    rd_reg(6'h01, 32'h8000_0010, "R4 irq status");
    rd_reg(6'h02, 32'h0000_0001, "R3 fast status");
    rd_reg(6'h04, 32'h0000_0001, "R8 class readback");

    wr_reg(6'h03, 32'hFFFF_FFFE);
    tick();
    chk(fiq, 1'b0, "R2 fiq drops after disable");
    chk(irq, 1'b1, "R2 irq stays");
    rd_reg(6'h00, 32'h8000_0011, "R1 raw ignores enable");

    wr_reg(6'h06, DFLT);
    wr_reg(6'h12, 32'h24); wr_reg(6'h22, H4);
    wr_reg(6'h15, 32'h3F); wr_reg(6'h25, H31);
    wr_reg(6'h17, 32'h28); wr_reg(6'h27, H8);
    wr_reg(6'h13, 32'h10);
    rd_reg(6'h12, 32'h24, "R8 slot ctrl readback");
    rd_reg(6'h25, H31, "R8 slot addr readback");

    rd_reg(6'h05, H4, "R5 best slot");
    rd_reg(6'h05, DFLT, "R7 held off same level");
    wr_reg(6'h05, 32'h0);
    rd_reg(6'h05, H4, "R7 released after eoi");
    wr_reg(6'h05, 32'h0);

    req = 32'h8000_0001;
    rd_reg(6'h05, H31, "R5 next slot");
    req = 32'h8000_0101;
    rd_reg(6'h05, DFLT, "R7 lower slot held off");
    rd_req(6'h05, 32'h8000_0111, H4, "R7 higher slot during active");
    wr_reg(6'h05, 32'h0);

    // same-cycle: request drop coincides with vector read
    req = 32'h8000_0111;
    rd_req(6'h05, 32'h8000_0101, H31, "R5 drop in read cycle");
    wr_reg(6'h05, 32'h0);

    req = 32'h0001_0000;
    rd_reg(6'h05, DFLT, "R6 plain only gives default");
    rd_req(6'h05, 32'h0001_0100, H8, "R6 no latch on default");
    wr_reg(6'h05, 32'h0);
    req = 32'h0;
    rd_reg(6'h05, DFLT, "R6 nothing pending");
    rd_reg(6'h05, H4 & 32'h0 | DFLT, "R6 still no latch");

    wr_reg(6'h04, 32'h0000_0010);
    req = 32'h0000_0010;
    rd_reg(6'h05, DFLT, "R3 fast source not vectored");
    rd_reg(6'h01, 32'h0, "R3 fast source not in irq status");
    tick();
    chk(fiq, 1'b1, "R3 fiq from reclassed source");
    chk(irq, 1'b0, "R3 irq low for fast only");

    wr_reg(6'h04, 32'h0);
    wr_reg(6'h12, 32'h04);
    rd_reg(6'h05, DFLT, "R5 disabled slot skipped");

    tick(); tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule